// File: doc/BRIEF.md
# Divider Configuration Port with Serial and Parallel Loading

This block holds the configuration for a frequency synthesizer: a 9-bit loop divider value, a 2-bit output divider code and a 3-bit test select. Firmware or board logic can write these values through one of two paths. The parallel path presents the divider values on wide inputs and uses a load strobe. The serial path shifts a 14-bit frame through a three-wire port made of clock, data and load.

Both paths behave as level-sensitive latches. The parallel latch follows its inputs while its strobe is low, and it holds from the moment the strobe rises. The serial latch follows the shift register while its strobe is high, and it holds from the moment that strobe falls. The parallel path wins over the serial path. While the parallel strobe is low, the serial strobe has no effect and the test select reads zero. The test select can only be set through the serial frame.

All four serial and strobe pins are asynchronous to the system clock. Each one passes through a synchronizer of `SYNC` flip-flops. Edges of the serial clock are then detected in the system clock domain. The parallel value inputs are expected to be stable around strobe edges and are not synchronized.

Top module: `divcfg_port`

## Requirements
- R1: While reset is asserted, the outputs read divider value 0x1FF, divider code 2'b11 and test select 3'b000. These all-ones divider values stand in for unconnected pulled-up inputs.
- R2: The shift register is 14 bits long. It advances once for each rising edge of `ser_clk` and takes in `ser_dat`. The first bit sent lands in `cfg_t[2]`, then come `cfg_t[1]`, `cfg_t[0]`, `cfg_n[1]` and `cfg_n[0]`. The last nine bits fill `cfg_m[8]` down to `cfg_m[0]`.
- R3: While `par_ld` is high and `ser_ld` is high, the outputs follow the shift register. A shift made during this window changes the outputs.
- R4: While `par_ld` is high and `ser_ld` is low, the outputs hold. Shifting a new frame leaves them unchanged.
- R5: While `par_ld` is low, `cfg_m` and `cfg_n` follow `par_m` and `par_n`.
- R6: After `par_ld` rises, later changes on `par_m` and `par_n` have no effect on the outputs.
- R7: While `par_ld` is low, `cfg_t` reads 3'b000 and a pulse on `ser_ld` has no effect. This holds even when the shifted frame carries a nonzero test select.
- R8: The value 262 (9'b100000110) with divider code 2'b01 gives identical outputs whether it is loaded through the parallel path or through the serial path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_dat | input | 1 | Serial data, sampled on rising `ser_clk` |
| ser_ld | input | 1 | Serial latch strobe, transparent while high |
| par_ld | input | 1 | Parallel latch strobe, transparent while low |
| par_m | input | M_W | Parallel loop divider value |
| par_n | input | N_W | Parallel output divider code |
| cfg_m | output | M_W | Latched loop divider value |
| cfg_n | output | N_W | Latched output divider code |
| cfg_t | output | T_W | Latched test select |

## Verification
The serial latch and the parallel latch can both be open in the same system clock cycle. This overlap is forced by raising `ser_ld` while `par_ld` is still low, after shifting a frame whose divider and test fields differ from the parallel inputs. The outputs are then judged against the parallel inputs with the test select at zero. In a second case, a shift is made while the serial latch is open, and the outputs are checked to track the new shift register contents in the bench's own model of the frame.

// File: rtl/divcfg_port.sv
module divcfg_port #(
  parameter int M_W  = 9,
  parameter int N_W  = 2,
  parameter int T_W  = 3,
  parameter int SYNC = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_clk,
  input  logic           ser_dat,
  input  logic           ser_ld,
  input  logic           par_ld,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  output logic [M_W-1:0] cfg_m,
  output logic [N_W-1:0] cfg_n,
  output logic [T_W-1:0] cfg_t
);
  localparam int SR_W = T_W + N_W + M_W;

  logic [SYNC-1:0] sclk_p, sdat_p, sld_p, pld_p;
  logic            sclk_d;
  logic [SR_W-1:0] sr;

  wire sclk_s    = sclk_p[SYNC-1];
  wire sdat_s    = sdat_p[SYNC-1];
  wire sld_s     = sld_p[SYNC-1];
  wire pld_s     = pld_p[SYNC-1];
  wire sclk_rise = sclk_s & ~sclk_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_p <= '0;
      sdat_p <= '0;
      sld_p  <= '0;
      pld_p  <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_p <= {sclk_p[SYNC-2:0], ser_clk};
      sdat_p <= {sdat_p[SYNC-2:0], ser_dat};
      sld_p  <= {sld_p[SYNC-2:0], ser_ld};
      pld_p  <= {pld_p[SYNC-2:0], par_ld};
      sclk_d <= sclk_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         sr <= '0;
    else if (sclk_rise) sr <= {sr[SR_W-2:0], sdat_s};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg_m <= '1;
      cfg_n <= '1;
      cfg_t <= '0;
    end else if (!pld_s) begin
      cfg_m <= par_m;
      cfg_n <= par_n;
      cfg_t <= '0;
    end else if (sld_s) begin
      {cfg_t, cfg_n, cfg_m} <= sr;
    end
endmodule

// File: rtl/divcfg_port_chk.sv
module divcfg_port_chk #(
  parameter int M_W = 9,
  parameter int N_W = 2,
  parameter int T_W = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   pld_s,
  input logic                   sld_s,
  input logic                   sclk_rise,
  input logic [T_W+N_W+M_W-1:0] sr,
  input logic [M_W-1:0]         par_m,
  input logic [N_W-1:0]         par_n,
  input logic [M_W-1:0]         cfg_m,
  input logic [N_W-1:0]         cfg_n,
  input logic [T_W-1:0]         cfg_t
);
  a_r2_shift_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> $stable(sr));

  a_r3_ser_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (pld_s && sld_s) |=> ({cfg_t, cfg_n, cfg_m} == $past(sr)));

  a_r4_ser_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pld_s && !sld_s) |=> ($stable(cfg_m) && $stable(cfg_n) && $stable(cfg_t)));

  a_r5_par_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !pld_s |=> (cfg_m == $past(par_m) && cfg_n == $past(par_n)));

  a_r7_test_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !pld_s |=> (cfg_t == '0));
endmodule

bind divcfg_port divcfg_port_chk #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pld_s(pld_s), .sld_s(sld_s),
  .sclk_rise(sclk_rise), .sr(sr), .par_m(par_m), .par_n(par_n),
  .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_t(cfg_t)
);

// File: tb/divcfg_port_tb_top.sv
module divcfg_port_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [8:0] m;
    logic [1:0] n;
    logic [2:0] t;
    string      req;
  } exp_t;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0, par_ld = 1'b0;
  logic [8:0] par_m = '0;
  logic [1:0] par_n = '0;
  logic [8:0] cfg_m;
  logic [1:0] cfg_n;
  logic [2:0] cfg_t;

  exp_t        q[$];
  int          vectors = 0, miscompares = 0;
  logic [13:0] model_sr = '0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  divcfg_port dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_ld(ser_ld), .par_ld(par_ld), .par_m(par_m), .par_n(par_n),
    .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_t(cfg_t)
  );

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      vectors++;
      if (cfg_m !== e.m || cfg_n !== e.n || cfg_t !== e.t) begin
        miscompares++;
        $display("FAIL %s: got m=%h n=%b t=%b, expected m=%h n=%b t=%b",
                 e.req, cfg_m, cfg_n, cfg_t, e.m, e.n, e.t);
      end
    end
  end

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(logic [8:0] m, logic [1:0] n, logic [2:0] t, string req);
    exp_t e;
    e.m = m; e.n = n; e.t = t; e.req = req;
    q.push_back(e);
    settle(2);
  endtask

  task automatic send_bit(logic b);
    ser_dat = b;
    settle(4);
    ser_clk = 1'b1;
    model_sr = {model_sr[12:0], b};
    settle(4);
    ser_clk = 1'b0;
  endtask

  task automatic send_frame(logic [2:0] t, logic [1:0] n, logic [8:0] m);
    logic [13:0] f;
    f = {t, n, m};
    for (int i = 13; i >= 0; i--) send_bit(f[i]);
    settle(6);
  endtask

  task automatic pulse_ser_ld();
    ser_ld = 1'b1;
    settle(8);
    ser_ld = 1'b0;
    settle(8);
  endtask

  initial begin
    settle(3);
    expect_now(9'h1FF, 2'b11, 3'b000, "R1");
    rst_n = 1'b1;

    par_m = 9'h0AB; par_n = 2'b10; settle(6);
    expect_now(9'h0AB, 2'b10, 3'b000, "R5");
    par_m = 9'h155; par_n = 2'b01; settle(6);
    expect_now(9'h155, 2'b01, 3'b000, "R5");

    par_m = 9'd262; par_n = 2'b01; settle(2);
    par_ld = 1'b1; settle(6);
    par_m = 9'h0F0; par_n = 2'b11; settle(6);
    expect_now(9'd262, 2'b01, 3'b000, "R6");
    expect_now(9'd262, 2'b01, 3'b000, "R8 parallel");

    send_frame(3'b101, 2'b10, 9'h1C3);
    expect_now(9'd262, 2'b01, 3'b000, "R4");
    pulse_ser_ld();
    expect_now(9'h1C3, 2'b10, 3'b101, "R2");

    send_frame(3'b011, 2'b00, 9'h00F);
    expect_now(9'h1C3, 2'b10, 3'b101, "R4");

    ser_ld = 1'b1; settle(8);
    expect_now(9'h00F, 2'b00, 3'b011, "R3");
    send_bit(1'b1); settle(6);
    expect_now(model_sr[8:0], model_sr[10:9], model_sr[13:11], "R3");
    ser_ld = 1'b0; settle(8);

    par_ld = 1'b0; settle(6);
    expect_now(9'h0F0, 2'b11, 3'b000, "R7");
    send_frame(3'b111, 2'b00, 9'h0AA);
    pulse_ser_ld();
    expect_now(9'h0F0, 2'b11, 3'b000, "R7");

    par_m = 9'h033; par_n = 2'b10; settle(2);
    par_ld = 1'b1; settle(6);
    send_frame(3'b000, 2'b01, 9'd262);
    pulse_ser_ld();
    expect_now(9'd262, 2'b01, 3'b000, "R8 serial");

    send_frame(3'b110, 2'b11, 9'h100);
    pulse_ser_ld();
    expect_now(9'h100, 2'b11, 3'b110, "R2");

    settle(4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule